// File: doc/BRIEF.md
# Posted-Write Up-Counting Timer

This block is a memory-mapped 32-bit timer that counts upward on pulses of a slow tick input. Software reaches it over a plain register bus (address, write data, write strobe, read strobe, combinational read data) and is served by a single level interrupt. The counter can run on every tick or through a power-of-two prescaler. It can wrap to zero or reload from a reload register, and it can flag a compare match against a match register. A capture input freezes the counter value into a capture register.

Writes to the control, counter, reload, trigger and match registers are posted. Each write raises its own bit in a pending register for a fixed window, which models the crossing into the timer's clock domain. The target takes the new value only when that bit drops, so software must poll the pending register before relying on the write. A one-shot delay of N ticks is set up by loading the counter with the two's-complement negative of N. The overflow flag then rises on the Nth tick.

Top module: `ptimer`

## Requirements
- R1: A read of offset 0x00 returns the revision parameter in bits 7:0, with the major number in bits 7:4 and the minor number in bits 3:0. All other bits read as zero.
- R2: The control register is at offset 0x24, with bit 0 = run, bit 1 = auto-reload, bits 4:2 = prescale value, bit 5 = prescale enable and bit 6 = compare enable. The counter is at offset 0x28. With run set and the prescaler off, the counter rises by one on each tick. With run clear, it holds its value.
- R3: When the counter advances from all-ones, status bit 1 (overflow) is set. The counter becomes the reload value (offset 0x2C) if auto-reload is set, and zero otherwise. Loading the counter with the negative of N sets overflow on the Nth tick.
- R4: With compare enabled, an advance that brings the counter equal to the match register (offset 0x38) sets status bit 0.
- R5: The pending register (offset 0x34) has bit 0 = control, bit 1 = counter, bit 2 = reload, bit 3 = trigger and bit 4 = match. A bit rises in the cycle after a write to its register and stays high for 4 clock cycles.
- R6: A posted register keeps its old value while its pending bit is high. It takes the written value in the cycle in which the bit drops.
- R7: The status register is at offset 0x18 and is write-1-to-clear; a set event wins over a clear in the same cycle. The enable register is at offset 0x1C and is written at once, with the same bit layout as status. The interrupt output is high exactly when some status bit and its enable bit are both set.
- R8: When a write to the trigger register (offset 0x30) commits, the counter is loaded from the reload register.
- R9: With the prescaler enabled, the counter advances once every 2^(prescale value + 1) ticks.
- R10: A one-cycle pulse on the capture input copies the counter into the capture register (offset 0x3C) and sets status bit 2.
- R11: A second write to a register whose pending bit is still high restarts that register's window, and only the last written value is committed.
- R12: After reset, the control, counter, reload, match, capture, status, enable and pending registers read zero, and the interrupt is low.
- R13: The trigger register and any unmapped offset (for example 0x20) read as zero, and writes to an unmapped offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Functional tick, one cycle per count step |
| cap_i | input | 1 | Capture request pulse |
| bus_addr_i | input | AW | Register byte offset |
| bus_wdata_i | input | DW | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DW | Read data, valid while the read strobe is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with its default parameters: a 32-bit counter, an 8-bit address, a pending window of 4 cycles and revision 0x21. The short window lets every posted write be polled to completion in a handful of cycles. It also makes it possible to observe a rewrite landing inside the window. The counter is never walked through its full 32-bit range. Instead, values just below all-ones are preloaded, so that wrap, auto-reload and the negative-duration one-shot are reached in a few ticks. Prescale values up to 3 keep the divided runs short while still showing the power-of-two spacing.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int NPOST = 5;
  localparam int PTV_W = 3;

  // posted register indices, also their pending bit positions
  localparam int PI_CTRL = 0;
  localparam int PI_CNT  = 1;
  localparam int PI_RLD  = 2;
  localparam int PI_TRG  = 3;
  localparam int PI_MAT  = 4;

  // status / enable bit positions
  localparam int SB_MAT = 0;
  localparam int SB_OVF = 1;
  localparam int SB_CAP = 2;
  localparam int NSB    = 3;

  localparam logic [7:0] OFF_ID   = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] OFF_ENA  = 8'h1C;
  localparam logic [7:0] OFF_CTRL = 8'h24;
  localparam logic [7:0] OFF_CNT  = 8'h28;
  localparam logic [7:0] OFF_RLD  = 8'h2C;
  localparam logic [7:0] OFF_TRG  = 8'h30;
  localparam logic [7:0] OFF_PEND = 8'h34;
  localparam logic [7:0] OFF_MAT  = 8'h38;
  localparam logic [7:0] OFF_CAP  = 8'h3C;

  typedef struct packed {
    logic             cmp_en;
    logic             pre_en;
    logic [PTV_W-1:0] ptv;
    logic             auto_rld;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [7:0] post_off(input int idx);
    case (idx)
      PI_CTRL: post_off = OFF_CTRL;
      PI_CNT:  post_off = OFF_CNT;
      PI_RLD:  post_off = OFF_RLD;
      PI_TRG:  post_off = OFF_TRG;
      default: post_off = OFF_MAT;
    endcase
  endfunction

endpackage

// File: rtl/ptimer_rst_sync.sv
module ptimer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/ptimer_post.sv
// One posted-write slot: holds written data for a fixed window, then commits.
module ptimer_post #(
  parameter int DW  = 32,
  parameter int WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          commit_o,
  output logic [DW-1:0] shadow_o
);

  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] win_q, win_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    win_d = win_q;
    sh_en = 1'b0;
    sh_d  = wdata_i;
    if (wr_i) begin
      win_d = WIN_C;     // a rewrite restarts the window
      sh_en = 1'b1;
    end else if (win_q != '0) begin
      win_d = win_q - ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      sh_q  <= '0;
    end else begin
      win_q <= win_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign pend_o   = (win_q != '0);
  assign commit_o = (win_q == ONE_C) && !wr_i;
  assign shadow_o = sh_q;

endmodule

// File: rtl/ptimer_prescale.sv
// Turns ticks into counter advance pulses, optionally divided by 2^(ptv+1).
module ptimer_prescale
  import ptimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             adv_o
);

  localparam int PCW = 1 << PTV_W;

  logic [PCW-1:0] pc_q, pc_d, lim;

  always_comb begin
    lim   = PCW'((64'd1 << (32'(ptv_i) + 32'd1)) - 64'd1);
    pc_d  = pc_q;
    adv_o = 1'b0;
    if (!run_i) begin
      pc_d = '0;
    end else if (tick_i) begin
      if (!pre_en_i) begin
        adv_o = 1'b1;
      end else if (pc_q == lim) begin
        pc_d  = '0;
        adv_o = 1'b1;
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/ptimer_core.sv
// Counter, capture and the event pulses that feed the status register.
module ptimer_core
  import ptimer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl_i,
  input  logic          adv_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_wdata_i,
  input  logic          trg_i,
  input  logic [DW-1:0] rld_i,
  input  logic [DW-1:0] mat_i,
  input  logic          cap_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cap_o,
  output logic [NSB-1:0] evt_o
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] cap_q;
  logic          wrap;

  always_comb begin
    cnt_d = cnt_q;
    evt_o = '0;
    wrap  = (cnt_q == '1);
    if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
    end else if (trg_i) begin
      cnt_d = rld_i;
    end else if (adv_i) begin
      if (wrap) begin
        evt_o[SB_OVF] = 1'b1;
        cnt_d = ctrl_i.auto_rld ? rld_i : '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (ctrl_i.cmp_en && (cnt_d == mat_i)) evt_o[SB_MAT] = 1'b1;
    end
    evt_o[SB_CAP] = cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cap_i) cap_q <= cnt_q;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int         DW       = 32,
  parameter int         AW       = 8,
  parameter int         POST_WIN = 4,
  parameter logic [7:0] REV      = 8'h21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cap_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);

  logic                rst_sn;
  logic [NPOST-1:0]    post_wr, pend, commit;
  logic [DW-1:0]       post_data [NPOST];

  ctrl_t               ctrl_q, ctrl_d;
  logic [DW-1:0]       rld_q, rld_d, mat_q, mat_d;
  logic [NSB-1:0]      stat_q, stat_d, ena_q, ena_d, evt, w1c;
  logic                ena_wr;
  logic [DW-1:0]       cnt, cap_val;
  logic                adv;
  logic                unused_bits;

  ptimer_rst_sync rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  for (genvar g = 0; g < NPOST; g++) begin : g_post
    assign post_wr[g] = bus_we_i && (bus_addr_i == AW'(post_off(g)));
    ptimer_post #(.DW(DW), .WIN(POST_WIN)) post_i (
      .clk      (clk),
      .rst_n    (rst_sn),
      .wr_i     (post_wr[g]),
      .wdata_i  (bus_wdata_i),
      .pend_o   (pend[g]),
      .commit_o (commit[g]),
      .shadow_o (post_data[g])
    );
  end

  assign unused_bits = ^{post_data[PI_CTRL][DW-1:CTRL_W], post_data[PI_TRG],
                         bus_wdata_i[DW-1:NSB]};

  // committed configuration
  always_comb begin
    ctrl_d = ctrl_q;
    rld_d  = rld_q;
    mat_d  = mat_q;
    if (commit[PI_CTRL]) ctrl_d = ctrl_t'(post_data[PI_CTRL][CTRL_W-1:0]);
    if (commit[PI_RLD])  rld_d  = post_data[PI_RLD];
    if (commit[PI_MAT])  mat_d  = post_data[PI_MAT];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      mat_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rld_q  <= rld_d;
      mat_q  <= mat_d;
    end
  end

  ptimer_prescale pre_i (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_i    (ctrl_q.run),
    .tick_i   (tick_i),
    .pre_en_i (ctrl_q.pre_en),
    .ptv_i    (ctrl_q.ptv),
    .adv_o    (adv)
  );

  ptimer_core #(.DW(DW)) core_i (
    .clk         (clk),
    .rst_n       (rst_sn),
    .ctrl_i      (ctrl_q),
    .adv_i       (adv),
    .cnt_wr_i    (commit[PI_CNT]),
    .cnt_wdata_i (post_data[PI_CNT]),
    .trg_i       (commit[PI_TRG]),
    .rld_i       (rld_q),
    .mat_i       (mat_q),
    .cap_i       (cap_i),
    .cnt_o       (cnt),
    .cap_o       (cap_val),
    .evt_o       (evt)
  );

  // status (write-1-to-clear, set wins) and enable (direct write)
  always_comb begin
    w1c    = (bus_we_i && (bus_addr_i == AW'(OFF_STAT))) ? bus_wdata_i[NSB-1:0] : '0;
    ena_wr = bus_we_i && (bus_addr_i == AW'(OFF_ENA));
    stat_d = (stat_q & ~w1c) | evt;
    ena_d  = bus_wdata_i[NSB-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stat_q <= '0;
      ena_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ena_wr) ena_q <= ena_d;
    end
  end

  assign irq_o = |(stat_q & ena_q);

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      case (bus_addr_i)
        AW'(OFF_ID):   bus_rdata_o = DW'(REV);
        AW'(OFF_STAT): bus_rdata_o = DW'(stat_q);
        AW'(OFF_ENA):  bus_rdata_o = DW'(ena_q);
        AW'(OFF_CTRL): bus_rdata_o = DW'(ctrl_q);
        AW'(OFF_CNT):  bus_rdata_o = cnt;
        AW'(OFF_RLD):  bus_rdata_o = rld_q;
        AW'(OFF_PEND): bus_rdata_o = DW'(pend);
        AW'(OFF_MAT):  bus_rdata_o = mat_q;
        AW'(OFF_CAP):  bus_rdata_o = cap_val;
        default:       bus_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk
  import ptimer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPOST-1:0] pend,
  input logic [NPOST-1:0] commit,
  input logic [DW-1:0]    cnt_shadow,
  input logic [DW-1:0]    cnt,
  input logic             run,
  input logic [NSB-1:0]   stat,
  input logic [NSB-1:0]   ena,
  input logic             irq
);

  assert_pend_src_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pend[PI_CTRL]) |-> $past(bus_we && (bus_addr == AW'(OFF_CTRL))));

  assert_rewrite_keeps_pend_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(bus_we && (bus_addr == AW'(OFF_CNT))) |-> pend[PI_CNT]);

  assert_cnt_commit_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(pend[PI_CNT]) |-> (cnt == $past(cnt_shadow)));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!$past(run) && !$past(commit[PI_CNT]) && !$past(commit[PI_TRG])) |-> (cnt == $past(cnt)));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (($past(cnt) == '1) && (cnt != $past(cnt)) && !$past(commit[PI_CNT])
     && !$past(commit[PI_TRG])) |-> stat[SB_OVF]);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ena == '0) |-> !irq);

endmodule

bind ptimer ptimer_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .bus_we     (bus_we_i),
  .bus_addr   (bus_addr_i),
  .pend       (pend),
  .commit     (commit),
  .cnt_shadow (post_data[1]),
  .cnt        (cnt),
  .run        (ctrl_q.run),
  .stat       (stat_q),
  .ena        (ena_q),
  .irq        (irq_o)
);

// File: tb/ptimer_tb_top.sv
`timescale 1ns/1ps
module ptimer_tb_top;

  localparam logic [7:0] A_ID = 8'h00, A_STAT = 8'h18, A_ENA = 8'h1C, A_HOLE = 8'h20,
                         A_CTRL = 8'h24, A_CNT = 8'h28, A_RLD = 8'h2C, A_TRG = 8'h30,
                         A_PEND = 8'h34, A_MAT = 8'h38, A_CAP = 8'h3C;

  // {ctrl, preload, reload, ticks, expected counter}
  localparam int NV = 7;
  localparam logic [143:0] VEC [NV] = '{
    {32'h01, 32'h0000_0000, 32'h0, 16'd10, 32'd10},        // R2 plain count
    {32'h21, 32'h0000_0000, 32'h0, 16'd10, 32'd5},         // R9 ptv0: /2
    {32'h25, 32'h0000_0000, 32'h0, 16'd12, 32'd3},         // R9 ptv1: /4
    {32'h00, 32'h0000_0007, 32'h0, 16'd5,  32'd7},         // R2 stopped holds
    {32'h01, 32'hFFFF_FFFE, 32'h0, 16'd3,  32'd1},         // R3 wrap to zero
    {32'h03, 32'hFFFF_FFFF, 32'h100, 16'd2, 32'h101},      // R3 auto-reload
    {32'h2D, 32'h0000_0000, 32'h0, 16'd32, 32'd2}          // R9 ptv3: /16
  };

  logic        clk, rst_n, tick, cap, bus_we, bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_chk, n_fail;

  ptimer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_i(cap),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_we_i(bus_we),
    .bus_re_i(bus_re), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string vreq(input int i);
    case (i)
      1, 2, 6: vreq = "R9";
      4, 5:    vreq = "R3";
      default: vreq = "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic poll();
    logic [31:0] v;
    do rd(A_PEND, v); while (v != 32'h0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, old;
    int hi;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; tick = 1'b0; cap = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd(A_CTRL, v); check("R12 ctrl", v, 32'h0);
    rd(A_CNT, v);  check("R12 counter", v, 32'h0);
    rd(A_PEND, v); check("R12 pending", v, 32'h0);
    rd(A_STAT, v); check("R12 status", v, 32'h0);
    check("R12 irq", {31'h0, irq}, 32'h0);
    // R1 revision
    rd(A_ID, v); check("R1 id", v, 32'h21);
    // R13 hole and trigger read zero
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, v); check("R13 hole", v, 32'h0);
    rd(A_TRG, v);  check("R13 trigger read", v, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c_ctrl, c_pre, c_rld, c_exp;
      logic [15:0] c_n;
      {c_ctrl, c_pre, c_rld, c_n, c_exp} = VEC[i];
      wr(A_RLD, c_rld); poll();
      wr(A_CNT, c_pre); poll();
      wr(A_CTRL, c_ctrl); poll();
      ticks(int'(c_n));
      wr(A_CTRL, 32'h0); poll();
      rd(A_CNT, v); check(vreq(i), v, c_exp);
      wr(A_STAT, 32'h7);
    end

    // R5/R6 pending window on reload
    wr(A_RLD, 32'h55);
    rd(A_PEND, v); check("R5 pend bit", v, 32'h4);
    rd(A_RLD, v);  check("R6 old value held", v, 32'h0);
    hi = 0;
    do begin rd(A_PEND, v); if (v != 0) hi++; end while (v != 0);
    check("R5 window length", 32'(hi), 32'd1); // two reads already inside the 4-cycle window, one more high
    rd(A_RLD, v); check("R6 committed", v, 32'h55);

    // R8 trigger
    wr(A_TRG, 32'h0); poll();
    rd(A_CNT, v); check("R8 trigger reload", v, 32'h55);

    // R11 rewrite during pending
    rd(A_CNT, old);
    wr(A_CNT, 32'hAAAA);
    wr(A_CNT, 32'hBBBB);
    rd(A_CNT, v);
    rd(A_CNT, v);  check("R11 first value dropped", v, old);
    rd(A_PEND, v); check("R11 still pending", v, 32'h2);
    poll();
    rd(A_CNT, v);  check("R11 last value", v, 32'hBBBB);

    // R3/R7 one-shot via negative duration
    wr(A_ENA, 32'h2);
    wr(A_CNT, 32'hFFFF_FFFB); poll();
    wr(A_CTRL, 32'h1); poll();
    ticks(4);
    check("R3 no irq before N", {31'h0, irq}, 32'h0);
    ticks(1);
    #1 check("R7 irq after N", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 32'h0); poll();
    rd(A_STAT, v); check("R3 overflow flag", v, 32'h2);
    rd(A_CNT, v);  check("R3 wrap no reload", v, 32'h0);
    rd(A_STAT, v); wr(A_STAT, v);
    rd(A_STAT, v); check("R7 w1c", v, 32'h0);
    check("R7 irq cleared", {31'h0, irq}, 32'h0);
    wr(A_ENA, 32'h0);

    // R4 compare match
    wr(A_MAT, 32'd3); poll();
    wr(A_CNT, 32'd0); poll();
    wr(A_CTRL, 32'h41); poll();
    ticks(2);
    rd(A_STAT, v); check("R4 no match yet", v, 32'h0);
    ticks(1);
    rd(A_STAT, v); check("R4 match flag", v, 32'h1);
    wr(A_CTRL, 32'h0); poll();
    wr(A_STAT, 32'h7);

    // R10 capture
    wr(A_CNT, 32'h1234); poll();
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    rd(A_CAP, v);  check("R10 capture value", v, 32'h1234);
    rd(A_STAT, v); check("R10 capture flag", v, 32'h4);

    summary();
    $finish;
  end

endmodule